// File: doc/BRIEF.md
# Four-Phase to Two-Phase Handshake Bridge

This block connects a return-to-zero request/acknowledge pair, on which it is the passive party, to a transition-signalled request/acknowledge pair, on which it is the active party. A new four-phase request is answered at once. The four-phase acknowledge is raised in the same clock cycle that the two-phase request toggles. The block does not wait for the far side. The two-phase acknowledge is collected later, while the four-phase side goes through its return-to-zero phase.

The block runs on a clock. Both incoming handshake wires pass through a synchroniser chain and then an edge detector. A two-state controller then follows a burst discipline. It waits until every event of the expected input burst has arrived, in any order. Only then does it issue the whole output burst from registers in a single cycle. While the controller is in its waiting state, it records which burst members have already been seen. Any event that does not belong to the current burst sets a protocol error flag. That flag stays set until reset.

Top module: `hs4to2_bridge`

## Requirements
- R1: While and after a synchronous reset with the handshake inputs low, `ack4_out`, `req2_out` and `proto_err` are all 0 and the controller is idle.
- R2: In the idle state, a rising `req4_in` raises `ack4_out` and toggles `req2_out`. Both change on the same clock edge, the (SYNC_STAGES+1)-th rising edge after the input change, and the controller enters its waiting state.
- R3: In the waiting state, `ack4_out` falls only after `req4_in` has fallen and `ack2_in` has toggled, in either order. `req2_out` does not change on that return.
- R4: A fall of `req4_in` and a toggle of `ack2_in` that reach the controller in the same cycle complete the waiting burst together.
- R5: `req2_out` changes only together with a rise of `ack4_out`. Its level after n completed requests since reset is n mod 2.
- R6: A toggle of `ack2_in` in the idle state sets `proto_err` and leaves `ack4_out` and `req2_out` unchanged.
- R7: In the waiting state, a second toggle of `ack2_in` or a re-rise of `req4_in` sets `proto_err`. The offending event is discarded, and the burst members already recorded stay recorded.
- R8: `proto_err` stays at 1 until reset and only reset clears it.
- R9: After a protocol error, well-formed handshakes still produce the outputs given in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req4_in | input | 1 | Four-phase request (asynchronous) |
| ack4_out | output | 1 | Four-phase acknowledge |
| req2_out | output | 1 | Two-phase request toggle |
| ack2_in | input | 1 | Two-phase acknowledge toggle (asynchronous) |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The hardest situations to reach are those where the order of the two return events matters. One is the case where both events arrive in the same synchronised cycle. The other is an illegal event that arrives after one burst member has already been recorded. The stimulus reaches the first case by driving both wires on the same falling clock edge, so that they pass through identical synchroniser chains in lockstep. It reaches the second by placing a re-rise of the request, or a second acknowledge toggle, between the two legal return events. A reference model in the bench predicts every output change and queues it for the monitor to compare.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } phase_t;

  typedef struct packed {
    logic rise;
    logic fall;
  } edges_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[LAST];
endmodule

// File: rtl/hs_edge.sv
module hs_edge
  import hs_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output edges_t           ev [WIDTH]
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign ev[i].rise = level[i] & ~prev_q[i];
      assign ev[i].fall = ~level[i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/hs_burst_ctrl.sv
module hs_burst_ctrl
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic r4_rise,
  input  logic r4_fall,
  input  logic a2_tog,
  output logic ack4_q,
  output logic req2_q,
  output logic err_q
);
  phase_t ph_q;
  logic   seen_r4_q, seen_a2_q;
  logic   bad_ev, seen_r4_n, seen_a2_n, burst_done;

  always_comb begin
    seen_r4_n  = seen_r4_q | r4_fall;
    seen_a2_n  = seen_a2_q | a2_tog;
    burst_done = seen_r4_n & seen_a2_n;
    if (ph_q == PH_IDLE)
      bad_ev = a2_tog | r4_fall;
    else
      bad_ev = r4_rise | (a2_tog & seen_a2_q) | (r4_fall & seen_r4_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      ack4_q    <= 1'b0;
      req2_q    <= 1'b0;
      err_q     <= 1'b0;
      seen_r4_q <= 1'b0;
      seen_a2_q <= 1'b0;
    end else if (bad_ev) begin
      err_q <= 1'b1;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (r4_rise) begin
            ack4_q    <= 1'b1;
            req2_q    <= ~req2_q;
            ph_q      <= PH_WAIT;
            seen_r4_q <= 1'b0;
            seen_a2_q <= 1'b0;
          end
        end
        default: begin
          if (burst_done) begin
            ack4_q    <= 1'b0;
            ph_q      <= PH_IDLE;
            seen_r4_q <= 1'b0;
            seen_a2_q <= 1'b0;
          end else begin
            seen_r4_q <= seen_r4_n;
            seen_a2_q <= seen_a2_n;
          end
        end
      endcase
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && r4_rise && !a2_tog && !r4_fall)
      |=> (ack4_q && req2_q != $past(req2_q)));

  assert_hold_until_r4_R3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && !seen_r4_q && !r4_fall) |=> ack4_q);

  assert_hold_until_a2_R3: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && !seen_a2_q && !a2_tog) |=> ack4_q);

  assert_joint_done_R4: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && r4_fall && a2_tog && !seen_r4_q && !seen_a2_q && !r4_rise)
      |=> (!ack4_q && $stable(req2_q)));

  assert_req_with_ack_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(req2_q) |-> $rose(ack4_q));

  assert_idle_stray_R6: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && a2_tog) |=> (err_q && $stable(ack4_q) && $stable(req2_q)));

  assert_wait_stray_R7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WAIT && r4_rise) |=> (err_q && ack4_q && $stable(req2_q)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/hs4to2_bridge.sv
module hs4to2_bridge
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req4_in,
  output logic ack4_out,
  output logic req2_out,
  input  logic ack2_in,
  output logic proto_err
);
  localparam int NLINES = 2;
  localparam int IDX_R4 = 0;
  localparam int IDX_A2 = 1;

  logic [NLINES-1:0] raw_lines, sync_lines;
  edges_t            ev [NLINES];
  logic              a2_tog;

  assign raw_lines[IDX_R4] = req4_in;
  assign raw_lines[IDX_A2] = ack2_in;

  hs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_lines),
    .sync_out (sync_lines)
  );

  hs_edge #(.WIDTH(NLINES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_lines),
    .ev    (ev)
  );

  assign a2_tog = ev[IDX_A2].rise | ev[IDX_A2].fall;

  hs_burst_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .r4_rise (ev[IDX_R4].rise),
    .r4_fall (ev[IDX_R4].fall),
    .a2_tog  (a2_tog),
    .ack4_q  (ack4_out),
    .req2_q  (req2_out),
    .err_q   (proto_err)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ack4_out && !req2_out && !proto_err));
endmodule

// File: tb/hs4to2_bridge_bench.sv
module hs4to2_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int SETTLE = SYNC + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req4_in = 1'b0;
  logic ack2_in = 1'b0;
  logic ack4_out, req2_out, proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs4to2_bridge #(.SYNC_STAGES(SYNC)) u_hs4to2_bridge (
    .clk(clk), .rst(rst), .req4_in(req4_in), .ack4_out(ack4_out),
    .req2_out(req2_out), .ack2_in(ack2_in), .proto_err(proto_err)
  );

  // reference model state
  bit m_wait = 0, m_sr4 = 0, m_sa2 = 0;
  bit e_a4 = 0, e_r2 = 0, e_err = 0;
  logic [1:0] expq [$];
  logic [1:0] last_seen = 2'b00;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_levels(input string tag);
    check({tag, " ack4"}, ack4_out, e_a4);
    check({tag, " req2"}, req2_out, e_r2);
    check({tag, " err"}, proto_err, e_err);
  endtask

  // driver: apply a stimulus, predict the result, queue expected output changes
  task automatic drive(input bit r4v, input bit a2t, input string tag, input bit lat);
    bit rise, fall, bad, old_a4, old_r2;
    rise = r4v & ~req4_in;
    fall = ~r4v & req4_in;
    old_a4 = e_a4; old_r2 = e_r2;
    if (!m_wait) bad = a2t | fall;
    else bad = rise | (a2t & m_sa2) | (fall & m_sr4);
    if (bad) e_err = 1;
    else if (!m_wait) begin
      if (rise) begin e_a4 = 1; e_r2 = ~e_r2; m_wait = 1; m_sr4 = 0; m_sa2 = 0; end
    end else begin
      if ((m_sr4 | fall) && (m_sa2 | a2t)) begin e_a4 = 0; m_wait = 0; m_sr4 = 0; m_sa2 = 0; end
      else begin m_sr4 |= fall; m_sa2 |= a2t; end
    end
    if ({e_a4, e_r2} != {old_a4, old_r2}) expq.push_back({e_a4, e_r2});
    @(negedge clk);
    req4_in = r4v;
    if (a2t) ack2_in = ~ack2_in;
    if (lat) begin
      repeat (SYNC) @(negedge clk);
      check({tag, " R2 latency early ack4"}, ack4_out, old_a4);
      check({tag, " R2 latency early req2"}, req2_out, old_r2);
      @(negedge clk);
      check({tag, " R2 latency on-time ack4"}, ack4_out, e_a4);
      check({tag, " R2 latency on-time req2"}, req2_out, e_r2);
      repeat (SETTLE - SYNC - 1) @(negedge clk);
    end else begin
      repeat (SETTLE) @(negedge clk);
    end
    check_levels(tag);
  endtask

  // monitor: compare each observed output change with the queued prediction
  always @(negedge clk) begin
    if (!rst && {ack4_out, req2_out} !== last_seen) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected output change actual=%b expected=%b",
                 {ack4_out, req2_out}, last_seen);
      end else begin
        logic [1:0] exp_v;
        exp_v = expq.pop_front();
        if ({ack4_out, req2_out} !== exp_v) begin
          errors++;
          $display("FAIL R3 output sequence actual=%b expected=%b", {ack4_out, req2_out}, exp_v);
        end
      end
      last_seen = {ack4_out, req2_out};
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_levels("R1 during reset");
    rst = 0;
    repeat (3) @(negedge clk);
    check_levels("R1 after reset");

    // R2 latency and R3 order: R4 falls first, then A2
    drive(1, 0, "R2 first request", 1);
    drive(0, 0, "R3 r4 fell, await a2", 0);
    drive(0, 1, "R3 a2 completes", 0);

    // R3 other order: A2 first, then R4 falls
    drive(1, 0, "R2 second request", 1);
    drive(1, 1, "R3 a2 first, await r4", 0);
    drive(0, 0, "R3 r4 completes", 0);

    // R4 both return events together
    drive(1, 0, "R5 third request toggles", 0);
    drive(0, 1, "R4 simultaneous return", 0);
    check("R5 parity after 3", req2_out, 1'b1);

    // R6 stray A2 in idle
    drive(0, 1, "R6 stray a2 idle", 0);

    // R7 re-rise of R4 while waiting
    drive(1, 0, "R9 request after error", 0);
    drive(0, 0, "R7 r4 fell", 0);
    drive(1, 0, "R7 r4 re-rise ignored", 0);
    drive(0, 0, "R7 second fall ignored", 0);
    drive(0, 1, "R7 a2 completes", 0);

    // R7 double A2 while waiting
    drive(1, 0, "R9 request", 0);
    drive(1, 1, "R7 a2 once", 0);
    drive(1, 1, "R7 a2 twice ignored", 0);
    drive(0, 0, "R7 r4 completes", 0);
    check("R8 err still set", proto_err, 1'b1);

    // R8 reset clears
    @(negedge clk); rst = 1;
    m_wait = 0; m_sr4 = 0; m_sa2 = 0; e_a4 = 0; e_r2 = 0; e_err = 0;
    req4_in = 0; ack2_in = 0;
    repeat (SETTLE) @(negedge clk);
    last_seen = {ack4_out, req2_out};
    check_levels("R8 reset clears");
    rst = 0;
    repeat (2) @(negedge clk);
    drive(1, 0, "R9 post-reset request", 1);
    drive(0, 1, "R4 post-reset return", 0);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R5 missing output changes actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule